// File: doc/BRIEF.md
# Universal Bus Transceiver Datapath

This block carries data in both directions between two parallel ports, called A and B. Each direction keeps one storage register per half-word. A latch-enable level, a transceiver-clock input and an active-low output enable control that register. The latch-enable level makes the register follow its source port on every system-clock edge. With latch enable low, the register keeps its value, or it takes in the source port when the transceiver clock rises. The ports are modelled as separate input, output and drive-enable signals, so a wrapper at chip level can join them into real pads.

The word has two halves of `HALF_W` bits each by default. With `split_mode` high, each half obeys its own control set. With `split_mode` low, the whole word obeys control set 0. A single `inhibit` input freezes the functional path while a test controller owns the pins.

Each storage cell has a two-state machine that tracks the last sampled level of the transceiver clock. The state `CK_SEEN_LOW` moves to `CK_SEEN_HIGH` when the clock is sampled high. The state `CK_SEEN_HIGH` moves to `CK_SEEN_LOW` when the clock is sampled low. Otherwise the state stays where it is. Reset puts the machine in `CK_SEEN_HIGH`. A capture fires only while the machine is in `CK_SEEN_LOW` and the clock is sampled high.

Top module: `ubt_datapath`

## Requirements
- R1: While `rst_n` is low, and on the first edge after reset, `a_out` and `b_out` are all zero and `a_oe` and `b_oe` are all 0. The clock trackers start in `CK_SEEN_HIGH`, so a transceiver clock that is already high gives no capture.
- R2: With `ab_le` high for a half, `b_out` of that half equals the value that `a_in` had at the previous system-clock edge. The latency is one cycle.
- R3: With `ab_le` low and `ab_ck` at the same level on two successive edges, `b_out` keeps its value whatever `a_in` does.
- R4: With `ab_le` low, `b_out` takes `a_in` on the edge where `ab_ck` is sampled high after being sampled low on the edge before. A falling transceiver clock captures nothing.
- R5: `b_oe` of a half equals the inverse of `ab_oe_n` sampled at the previous edge. 1 means the port drives. 0 means high impedance.
- R6: The B-to-A direction behaves the same as R2 to R5, using `ba_le`, `ba_ck`, `ba_oe_n`, `b_in`, `a_out` and `a_oe`.
- R7: With `split_mode` = 1, half 1 (bits 17:9) uses control bit 1 and half 0 (bits 8:0) uses bit 0. With `split_mode` = 0, both halves use bit 0 and control bit 1 has no effect.
- R8: While `inhibit` is high, all outputs keep their values. The clock tracker keeps sampling, so a rise that happens during inhibit is not captured after release.
- R9: With both directions enabled at once, each port drives its own register and nothing arbitrates between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inhibit | input | 1 | Freezes storage and drive enables |
| split_mode | input | 1 | 1: independent halves, 0: one full-width word |
| a_in | input | 18 | A port input data |
| b_in | input | 18 | B port input data |
| ab_oe_n | input | 2 | A-to-B drive enable per half, active low |
| ab_le | input | 2 | A-to-B latch enable per half |
| ab_ck | input | 2 | A-to-B transceiver clock per half |
| ba_oe_n | input | 2 | B-to-A drive enable per half, active low |
| ba_le | input | 2 | B-to-A latch enable per half |
| ba_ck | input | 2 | B-to-A transceiver clock per half |
| a_out | output | 18 | A port driven data |
| a_oe | output | 2 | A port drive enable per half |
| b_out | output | 18 | B port driven data |
| b_oe | output | 2 | B port drive enable per half |

## Verification
The bench steps through several patterns:
- Alternating and walking data with latch enable high separates transparent following from stale storage.
- Data that changes while the transceiver clock is held low, and then held high, shows that a held register ignores its port.
- Rising and falling clock steps in turn show that only the low-to-high step captures.
- Runs in split mode and in merged mode, with opposite control bits on the two halves, show which control set each half obeys.
- A clock rise placed inside an inhibit window, with both directions enabled together, shows that the freeze holds and that no stale edge is captured after release.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
    typedef enum logic {
        CK_SEEN_LOW  = 1'b0,
        CK_SEEN_HIGH = 1'b1
    } ck_state_e;
endpackage

// File: rtl/ubt_store_cell.sv
module ubt_store_cell #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         freeze,
    input  logic         le,
    input  logic         ck,
    input  logic         oe_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         oe
);
    import ubt_pkg::*;

    ck_state_e    st, st_nx;
    logic [W-1:0] q_nx;
    logic         oe_nx;

    // next state: follow the sampled transceiver clock level
    always_comb begin
        unique case (st)
            CK_SEEN_LOW:  st_nx = ck ? CK_SEEN_HIGH : CK_SEEN_LOW;
            CK_SEEN_HIGH: st_nx = ck ? CK_SEEN_HIGH : CK_SEEN_LOW;
            default:      st_nx = CK_SEEN_HIGH;
        endcase
    end

    // storage and drive-enable decisions
    always_comb begin
        q_nx  = q;
        oe_nx = oe;
        if (!freeze) begin
            oe_nx = !oe_n;
            if (le) begin
                q_nx = d;
            end else if (st == CK_SEEN_LOW && ck) begin
                q_nx = d;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= CK_SEEN_HIGH;
        end else begin
            st <= st_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q  <= '0;
            oe <= 1'b0;
        end else begin
            q  <= q_nx;
            oe <= oe_nx;
        end
    end
endmodule

// File: rtl/ubt_dir_path.sv
module ubt_dir_path #(
    parameter int HALF_W = 9,
    parameter int HALVES = 2,
    localparam int WORD_W = HALF_W * HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze,
    input  logic              split_mode,
    input  logic [HALVES-1:0] le,
    input  logic [HALVES-1:0] ck,
    input  logic [HALVES-1:0] oe_n,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q,
    output logic [HALVES-1:0] oe
);
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic le_s, ck_s, oe_n_s;

        // half h uses its own controls when split, otherwise control set 0
        assign le_s   = split_mode ? le[h]   : le[0];
        assign ck_s   = split_mode ? ck[h]   : ck[0];
        assign oe_n_s = split_mode ? oe_n[h] : oe_n[0];

        ubt_store_cell #(.W(HALF_W)) cell_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .freeze (freeze),
            .le     (le_s),
            .ck     (ck_s),
            .oe_n   (oe_n_s),
            .d      (d[h*HALF_W +: HALF_W]),
            .q      (q[h*HALF_W +: HALF_W]),
            .oe     (oe[h])
        );
    end
endmodule

// File: rtl/ubt_datapath.sv
module ubt_datapath #(
    parameter int HALF_W = 9,
    parameter int HALVES = 2,
    localparam int WORD_W = HALF_W * HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inhibit,
    input  logic              split_mode,
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    input  logic [HALVES-1:0] ab_oe_n,
    input  logic [HALVES-1:0] ab_le,
    input  logic [HALVES-1:0] ab_ck,
    input  logic [HALVES-1:0] ba_oe_n,
    input  logic [HALVES-1:0] ba_le,
    input  logic [HALVES-1:0] ba_ck,
    output logic [WORD_W-1:0] a_out,
    output logic [HALVES-1:0] a_oe,
    output logic [WORD_W-1:0] b_out,
    output logic [HALVES-1:0] b_oe
);
    ubt_dir_path #(.HALF_W(HALF_W), .HALVES(HALVES)) ab_path_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .freeze     (inhibit),
        .split_mode (split_mode),
        .le         (ab_le),
        .ck         (ab_ck),
        .oe_n       (ab_oe_n),
        .d          (a_in),
        .q          (b_out),
        .oe         (b_oe)
    );

    ubt_dir_path #(.HALF_W(HALF_W), .HALVES(HALVES)) ba_path_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .freeze     (inhibit),
        .split_mode (split_mode),
        .le         (ba_le),
        .ck         (ba_ck),
        .oe_n       (ba_oe_n),
        .d          (b_in),
        .q          (a_out),
        .oe         (a_oe)
    );
endmodule

// File: rtl/ubt_datapath_chk.sv
module ubt_datapath_chk #(
    parameter int HW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          inhibit,
    input logic [HW-1:0] a_lo,
    input logic [HW-1:0] b_lo,
    input logic          ab_le0,
    input logic          ab_ck0,
    input logic          ab_oe_n0,
    input logic          ba_le0,
    input logic          ba_ck0,
    input logic [HW-1:0] a_out_lo,
    input logic [HW-1:0] b_out_lo,
    input logic          b_oe0,
    input logic          a_oe0
);
    // set once a full cycle out of reset has passed, so $past is meaningful
    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r2_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (!inhibit && ab_le0) |=> (b_out_lo == $past(a_lo)));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !inhibit && !ab_le0 && ab_ck0 == $past(ab_ck0)) |=> $stable(b_out_lo));

    a_r4_rise_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !inhibit && !ab_le0 && !$past(ab_ck0) && ab_ck0) |=> (b_out_lo == $past(a_lo)));

    a_r5_drive_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !inhibit |=> (b_oe0 == !$past(ab_oe_n0)));

    a_r6_back_path: assert property (@(posedge clk) disable iff (!rst_n)
        (!inhibit && ba_le0) |=> (a_out_lo == $past(b_lo)));

    a_r6_back_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !inhibit && !ba_le0 && ba_ck0 == $past(ba_ck0)) |=> $stable(a_out_lo));

    a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit |=> ($stable(b_out_lo) && $stable(a_out_lo) && $stable(b_oe0) && $stable(a_oe0)));
endmodule

bind ubt_datapath ubt_datapath_chk #(.HW(HALF_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .inhibit  (inhibit),
    .a_lo     (a_in[HALF_W-1:0]),
    .b_lo     (b_in[HALF_W-1:0]),
    .ab_le0   (ab_le[0]),
    .ab_ck0   (ab_ck[0]),
    .ab_oe_n0 (ab_oe_n[0]),
    .ba_le0   (ba_le[0]),
    .ba_ck0   (ba_ck[0]),
    .a_out_lo (a_out[HALF_W-1:0]),
    .b_out_lo (b_out[HALF_W-1:0]),
    .b_oe0    (b_oe[0]),
    .a_oe0    (a_oe[0])
);

// File: tb/ubt_datapath_tb_top.sv
module ubt_datapath_tb_top;
    localparam int HW = 9;
    localparam int NH = 2;
    localparam int WW = HW * NH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inhibit = 1'b0;
    logic split_mode = 1'b1;
    logic [WW-1:0] a_in = '0, b_in = '0;
    logic [NH-1:0] ab_oe_n = '1, ab_le = '0, ab_ck = '1;
    logic [NH-1:0] ba_oe_n = '1, ba_le = '0, ba_ck = '1;
    logic [WW-1:0] a_out, b_out;
    logic [NH-1:0] a_oe, b_oe;

    always #2 clk = ~clk;

    ubt_datapath #(.HALF_W(HW), .HALVES(NH)) dut_i (
        .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .split_mode(split_mode),
        .a_in(a_in), .b_in(b_in),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_ck(ab_ck),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_ck(ba_ck),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    typedef struct {
        logic [WW-1:0] a_o;
        logic [WW-1:0] b_o;
        logic [NH-1:0] a_e;
        logic [NH-1:0] b_e;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state built from the requirements
    logic [WW-1:0] m_a, m_b;
    logic [NH-1:0] m_ae, m_be, m_pab, m_pba;

    task automatic model_edge();
        if (!rst_n) begin
            m_a = '0; m_b = '0; m_ae = '0; m_be = '0;
            m_pab = '1; m_pba = '1;
        end else begin
            for (int h = 0; h < NH; h++) begin
                int c;
                logic le1, ck1, oe1, le2, ck2, oe2;
                c = split_mode ? h : 0;
                le1 = ab_le[c]; ck1 = ab_ck[c]; oe1 = ab_oe_n[c];
                le2 = ba_le[c]; ck2 = ba_ck[c]; oe2 = ba_oe_n[c];
                if (!inhibit) begin
                    m_be[h] = !oe1;
                    if (le1 || (!m_pab[h] && ck1)) m_b[h*HW +: HW] = a_in[h*HW +: HW];
                    m_ae[h] = !oe2;
                    if (le2 || (!m_pba[h] && ck2)) m_a[h*HW +: HW] = b_in[h*HW +: HW];
                end
                m_pab[h] = ck1;
                m_pba[h] = ck2;
            end
        end
    endtask

    // driver: inputs already set at a falling edge; model the next rising edge
    task automatic step(input string tag);
        exp_t e;
        @(posedge clk);
        model_edge();
        e.a_o = m_a; e.b_o = m_b; e.a_e = m_ae; e.b_e = m_be; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    // monitor
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (a_out !== e.a_o || b_out !== e.b_o || a_oe !== e.a_e || b_oe !== e.b_e) begin
                errors++;
                $display("FAIL %s: got a_out=%h b_out=%h a_oe=%b b_oe=%b exp a_out=%h b_out=%h a_oe=%b b_oe=%b",
                         e.tag, a_out, b_out, a_oe, b_oe, e.a_o, e.b_o, e.a_e, e.b_e);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1 reset state
        step("R1 reset");
        step("R1 reset");
        rst_n = 1'b1;
        step("R1 first edge, high clock gives no capture");

        // R2 transparent, split mode, alternating and walking patterns
        ab_oe_n = '0; ab_le = '1; a_in = 18'h2AAAA;
        step("R5 drive enable");
        a_in = 18'h15555; step("R2 alternating");
        for (int i = 0; i < 6; i++) begin
            a_in = 18'h1 << (i * 3);
            step("R2 walking");
        end

        // R3 hold: latch enable low, clock held low then held high
        ab_le = '0; ab_ck = '0; a_in = 18'h3C3C3; step("R3 hold low");
        a_in = 18'h0F0F0; step("R3 hold low");
        // R4 rise capture
        ab_ck = '1; a_in = 18'h12345; step("R4 rising capture");
        a_in = 18'h0BEEF; step("R3 hold high");
        ab_ck = '0; a_in = 18'h00777; step("R4 falling no capture");

        // R5 drive disable
        ab_oe_n = '1; step("R5 disable");
        ab_oe_n = '0; step("R5 enable");

        // R6 back path and R9 both directions enabled together
        ba_oe_n = '0; ba_le = '1; b_in = 18'h2D2D2; a_in = 18'h11111; ab_le = '1;
        step("R9 both enabled");
        ba_le = '0; ba_ck = '0; b_in = 18'h00001; step("R6 back hold");
        ba_ck = '1; b_in = 18'h3FFFF; step("R6 back rising capture");

        // R7 split: halves take opposite controls
        ab_le = 2'b01; a_in = 18'h3FE01; step("R7 split half select");
        ab_oe_n = 2'b10; step("R7 split drive enable");
        // R7 merged: control bit 1 ignored
        split_mode = 1'b0; ab_le = 2'b10; ab_ck = 2'b00; a_in = 18'h2468A;
        step("R7 merged bit1 ignored");
        ab_le = 2'b01; ab_oe_n = 2'b01; step("R7 merged follows bit0");
        ab_le = 2'b00; ab_oe_n = 2'b00; a_in = 18'h13579; step("R7 merged hold");

        // R8 inhibit, with a clock rise inside the window
        inhibit = 1'b1; ab_le = '1; ab_oe_n = '1; a_in = 18'h0AAAA; step("R8 frozen");
        ab_le = '0; ab_ck = '1; step("R8 frozen rise");
        inhibit = 1'b0; ab_oe_n = '0; a_in = 18'h05555; step("R8 no stale capture");
        ab_ck = '0; step("R8 after release");
        ab_ck = '1; a_in = 18'h01234; step("R4 capture after release");

        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule